// File: doc/BRIEF.md
# 64-bit SECDED Error Checker

This block checks one 64-bit data word against the 8 check bits stored with it. The word arrives as an upper and a lower 32-bit half, together with the stored check code and an input strobe. The block computes a fresh check code from the data and XORs it with the stored code to form the syndrome. It then sorts the syndrome into one of four results and repairs the word when the error is correctable.

The four results are: no error, one flipped data bit (with its position 0..63), one flipped check bit (with its position 0..7), and uncorrectable. Every check bit's parity mask is a parameter, stored as an upper-half and a lower-half table.

A data-bit failure is found by comparing the syndrome with every data bit's column of that table. A check-bit failure is a syndrome with exactly one bit set that matches no data column. The block has no state machine. Its only sequential element is the result register, which loads on the strobe and otherwise holds.

Top module: `ecc64_checker`

## Requirements
- R1: `gen_code[k]` is the XOR of the data bits selected by mask k: the upper mask applies to `in_hi` and the lower mask to `in_lo`. In the default table, the column of data bit b (bit b of every mask, with b 0..31 in `in_lo` and 32..63 in `in_hi`) is the b-th 8-bit value when the values of weight 3 and then weight 5 are each listed in ascending numeric order.
- R2: `syndrome` equals `gen_code` XOR the received `in_code`.
- R3: A zero syndrome gives `err_kind` 0 (none) and `err_index` 0, and the corrected outputs equal the received word and code.
- R4: A syndrome equal to the column of data bit b gives `err_kind` 1 and `err_index` b. The corrected data is the received data with bit b flipped: bit b-32 of the upper half when b is 32 or more, otherwise bit b of the lower half. The code is unchanged.
- R5: A syndrome with exactly one set bit k that matches no data column gives `err_kind` 2 and `err_index` k. The corrected code has bit k flipped and the data is unchanged.
- R6: Any other nonzero syndrome gives `err_kind` 3 (uncorrectable) and `err_index` 0, and the corrected outputs equal the received word and code. Every flip of two distinct bits among the 72 gives this result.
- R7: The results load at the clock edge where `in_valid` is high. `out_valid` is high in exactly the cycle after each such edge.
- R8: While `in_valid` is low, all result outputs hold their values and `out_valid` is 0.
- R9: During reset (`rst_n` low), `out_valid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: check the word on this edge |
| in_hi | input | 32 | Data bits 63..32 |
| in_lo | input | 32 | Data bits 31..0 |
| in_code | input | 8 | Stored check code |
| out_valid | output | 1 | Results are fresh this cycle |
| gen_code | output | 8 | Check code recomputed from the data |
| syndrome | output | 8 | gen_code XOR in_code |
| err_kind | output | 2 | 0 none, 1 data bit, 2 check bit, 3 uncorrectable |
| err_index | output | 6 | Failing bit position (data 0..63, check 0..7) |
| corr_hi | output | 32 | Corrected data bits 63..32 |
| corr_lo | output | 32 | Corrected data bits 31..0 |
| corr_code | output | 8 | Corrected check code |

## Verification
On every cycle, the assertions check four relations:
- each valid syndrome is the XOR of the fresh code and the previous cycle's input code;
- a no-error or check-bit result leaves the data untouched, and a data-bit repair changes exactly one data bit;
- a check-bit result always has a one-hot syndrome;
- outputs hold while the strobe is low.

Whether the failing position is the right one, and whether every double flip is refused, can only be shown by the bench's sweeps. The bench flips each of the 72 bits and every pair of bits, and compares the results with a code model built from R1.

// File: rtl/ecc64_pkg.sv
package ecc64_pkg;

    localparam int HALF_W    = 32;
    localparam int CHK_W     = 8;
    localparam int DATA_W    = 2 * HALF_W;
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int CHK_IDX_W = $clog2(CHK_W);

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_CHECK = 2'd2,
        KIND_MULTI = 2'd3
    } err_kind_e;

    typedef logic [CHK_W-1:0][HALF_W-1:0] mask_half_t;
    typedef logic [CHK_W-1:0][DATA_W-1:0] mask_full_t;

    // Odd-weight columns (weight 3 first, then 5), ascending, one per data bit.
    function automatic mask_full_t build_masks();
        mask_full_t m;
        int         used;
        int         ones;
        m    = '0;
        used = 0;
        for (int w = 3; w <= CHK_W; w += 2) begin
            for (int v = 0; v < (1 << CHK_W); v++) begin
                ones = 0;
                for (int k = 0; k < CHK_W; k++) begin
                    ones += (v >> k) & 1;
                end
                if (ones == w && used < DATA_W) begin
                    for (int k = 0; k < CHK_W; k++) begin
                        m[k][used] = ((v >> k) & 1) != 0;
                    end
                    used++;
                end
            end
        end
        return m;
    endfunction

    function automatic mask_half_t split_half(mask_full_t m, bit upper);
        mask_half_t h;
        for (int k = 0; k < CHK_W; k++) begin
            h[k] = upper ? m[k][DATA_W-1:HALF_W] : m[k][HALF_W-1:0];
        end
        return h;
    endfunction

    localparam mask_full_t DEFAULT_MASKS = build_masks();

endpackage

// File: rtl/ecc64_encoder.sv
module ecc64_encoder
    import ecc64_pkg::*;
#(
    parameter mask_half_t MASK_HI = split_half(DEFAULT_MASKS, 1'b1),
    parameter mask_half_t MASK_LO = split_half(DEFAULT_MASKS, 1'b0)
) (
    input  logic [HALF_W-1:0] word_hi,
    input  logic [HALF_W-1:0] word_lo,
    output logic [CHK_W-1:0]  code
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_parity
        assign code[k] = (^(word_hi & MASK_HI[k])) ^ (^(word_lo & MASK_LO[k]));
    end

endmodule

// File: rtl/ecc64_locator.sv
module ecc64_locator
    import ecc64_pkg::*;
#(
    parameter mask_half_t MASK_HI = split_half(DEFAULT_MASKS, 1'b1),
    parameter mask_half_t MASK_LO = split_half(DEFAULT_MASKS, 1'b0)
) (
    input  logic [CHK_W-1:0] syn,
    output err_kind_e        kind,
    output logic [IDX_W-1:0] index
);

    logic [DATA_W-1:0][CHK_W-1:0] column;
    logic [DATA_W-1:0]            hit;
    logic [IDX_W-1:0]             data_pos;
    logic [CHK_IDX_W-1:0]         chk_pos;
    logic                         one_set;

    for (genvar b = 0; b < DATA_W; b++) begin : g_col
        localparam int  POS   = b % HALF_W;
        localparam bit  UPPER = (b >= HALF_W);
        for (genvar k = 0; k < CHK_W; k++) begin : g_bit
            if (UPPER) begin : g_hi
                assign column[b][k] = MASK_HI[k][POS];
            end else begin : g_lo
                assign column[b][k] = MASK_LO[k][POS];
            end
        end
        assign hit[b] = (syn == column[b]);
    end

    always_comb begin
        data_pos = '0;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            if (hit[b]) data_pos = IDX_W'(b);
        end
    end

    always_comb begin
        chk_pos = '0;
        for (int k = CHK_W - 1; k >= 0; k--) begin
            if (syn[k]) chk_pos = CHK_IDX_W'(k);
        end
    end

    assign one_set = (syn != '0) && ((syn & (syn - CHK_W'(1))) == '0);

    always_comb begin
        kind  = KIND_MULTI;
        index = '0;
        if (syn == '0) begin
            kind = KIND_NONE;
        end else if (|hit) begin
            kind  = KIND_DATA;
            index = data_pos;
        end else if (one_set) begin
            kind  = KIND_CHECK;
            index = IDX_W'(chk_pos);
        end
    end

endmodule

// File: rtl/ecc64_fixer.sv
module ecc64_fixer
    import ecc64_pkg::*;
(
    input  logic [HALF_W-1:0] word_hi,
    input  logic [HALF_W-1:0] word_lo,
    input  logic [CHK_W-1:0]  code,
    input  err_kind_e         kind,
    input  logic [IDX_W-1:0]  index,
    output logic [HALF_W-1:0] fix_hi,
    output logic [HALF_W-1:0] fix_lo,
    output logic [CHK_W-1:0]  fix_code
);

    logic [DATA_W-1:0] data_flip;
    logic [CHK_W-1:0]  code_flip;

    always_comb begin
        data_flip = '0;
        code_flip = '0;
        unique case (kind)
            KIND_DATA:  data_flip = DATA_W'(1) << index;
            KIND_CHECK: code_flip = CHK_W'(1) << index[CHK_IDX_W-1:0];
            KIND_NONE,
            KIND_MULTI: ;
        endcase
    end

    assign fix_hi   = word_hi ^ data_flip[DATA_W-1:HALF_W];
    assign fix_lo   = word_lo ^ data_flip[HALF_W-1:0];
    assign fix_code = code ^ code_flip;

endmodule

// File: rtl/ecc64_checker.sv
module ecc64_checker
    import ecc64_pkg::*;
#(
    parameter mask_half_t MASK_HI = split_half(DEFAULT_MASKS, 1'b1),
    parameter mask_half_t MASK_LO = split_half(DEFAULT_MASKS, 1'b0)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_hi,
    input  logic [31:0] in_lo,
    input  logic [7:0]  in_code,
    output logic        out_valid,
    output logic [7:0]  gen_code,
    output logic [7:0]  syndrome,
    output logic [1:0]  err_kind,
    output logic [5:0]  err_index,
    output logic [31:0] corr_hi,
    output logic [31:0] corr_lo,
    output logic [7:0]  corr_code
);

    logic [CHK_W-1:0]  gen_c;
    logic [CHK_W-1:0]  syn_c;
    err_kind_e         kind_c;
    logic [IDX_W-1:0]  idx_c;
    logic [HALF_W-1:0] fix_hi_c;
    logic [HALF_W-1:0] fix_lo_c;
    logic [CHK_W-1:0]  fix_code_c;

    ecc64_encoder #(.MASK_HI(MASK_HI), .MASK_LO(MASK_LO)) u_encoder (
        .word_hi (in_hi),
        .word_lo (in_lo),
        .code    (gen_c)
    );

    assign syn_c = gen_c ^ in_code;

    ecc64_locator #(.MASK_HI(MASK_HI), .MASK_LO(MASK_LO)) u_locator (
        .syn   (syn_c),
        .kind  (kind_c),
        .index (idx_c)
    );

    ecc64_fixer u_fixer (
        .word_hi  (in_hi),
        .word_lo  (in_lo),
        .code     (in_code),
        .kind     (kind_c),
        .index    (idx_c),
        .fix_hi   (fix_hi_c),
        .fix_lo   (fix_lo_c),
        .fix_code (fix_code_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            gen_code  <= '0;
            syndrome  <= '0;
            err_kind  <= '0;
            err_index <= '0;
            corr_hi   <= '0;
            corr_lo   <= '0;
            corr_code <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                gen_code  <= gen_c;
                syndrome  <= syn_c;
                err_kind  <= kind_c;
                err_index <= idx_c;
                corr_hi   <= fix_hi_c;
                corr_lo   <= fix_lo_c;
                corr_code <= fix_code_c;
            end
        end
    end

endmodule

// File: rtl/ecc64_checker_sva.sv
module ecc64_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_hi,
    input logic [31:0] in_lo,
    input logic [7:0]  in_code,
    input logic        out_valid,
    input logic [7:0]  gen_code,
    input logic [7:0]  syndrome,
    input logic [1:0]  err_kind,
    input logic [5:0]  err_index,
    input logic [31:0] corr_hi,
    input logic [31:0] corr_lo,
    input logic [7:0]  corr_code
);

    // R2
    syndrome_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (syndrome == (gen_code ^ $past(in_code))));

    // R3
    clean_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_kind == 2'd0) |-> (syndrome == 8'd0 && corr_code == $past(in_code)));

    // R4
    data_single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_kind == 2'd1) |->
            ($countones({corr_hi ^ $past(in_hi), corr_lo ^ $past(in_lo)}) == 1
             && corr_code == $past(in_code)));

    // R5
    check_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_kind == 2'd2) |->
            ($countones(syndrome) == 1 && syndrome[err_index[2:0]]
             && corr_hi == $past(in_hi) && corr_lo == $past(in_lo)));

    // R6
    multi_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_kind == 2'd3) |->
            (syndrome != 8'd0 && corr_hi == $past(in_hi) && corr_lo == $past(in_lo)
             && corr_code == $past(in_code)));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(syndrome) && $stable(err_kind)
                       && $stable(corr_hi) && $stable(corr_lo) && $stable(corr_code)));

endmodule

bind ecc64_checker ecc64_checker_sva i_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_hi     (in_hi),
    .in_lo     (in_lo),
    .in_code   (in_code),
    .out_valid (out_valid),
    .gen_code  (gen_code),
    .syndrome  (syndrome),
    .err_kind  (err_kind),
    .err_index (err_index),
    .corr_hi   (corr_hi),
    .corr_lo   (corr_lo),
    .corr_code (corr_code)
);

// File: tb/test_ecc64_checker.sv
module test_ecc64_checker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_hi;
    logic [31:0] in_lo;
    logic [7:0]  in_code;
    logic        out_valid;
    logic [7:0]  gen_code;
    logic [7:0]  syndrome;
    logic [1:0]  err_kind;
    logic [5:0]  err_index;
    logic [31:0] corr_hi;
    logic [31:0] corr_lo;
    logic [7:0]  corr_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] colt [64];

    always #4 clk = ~clk;

    ecc64_checker i_ecc64_checker (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_hi     (in_hi),
        .in_lo     (in_lo),
        .in_code   (in_code),
        .out_valid (out_valid),
        .gen_code  (gen_code),
        .syndrome  (syndrome),
        .err_kind  (err_kind),
        .err_index (err_index),
        .corr_hi   (corr_hi),
        .corr_lo   (corr_lo),
        .corr_code (corr_code)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic [31:0] hi, input logic [31:0] lo);
        logic [63:0] d;
        logic [7:0]  c;
        d = {hi, lo};
        c = '0;
        for (int b = 0; b < 64; b++) begin
            if (d[b]) c ^= colt[b];
        end
        return c;
    endfunction

    task automatic apply(input logic [31:0] hi, input logic [31:0] lo, input logic [7:0] code);
        @(negedge clk);
        in_valid = 1'b1;
        in_hi    = hi;
        in_lo    = lo;
        in_code  = code;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_case(input logic [71:0] rx, input logic [1:0] ek, input logic [5:0] ei,
                            input logic [71:0] fixed, input string rq);
        logic [7:0] g;
        g = enc(rx[63:32], rx[31:0]);
        apply(rx[63:32], rx[31:0], rx[71:64]);
        chk("R7 out_valid", 64'(out_valid), 64'd1);
        chk("R1 gen_code", 64'(gen_code), 64'(g));
        chk("R2 syndrome", 64'(syndrome), 64'(g ^ rx[71:64]));
        chk({rq, " err_kind"}, 64'(err_kind), 64'(ek));
        chk({rq, " err_index"}, 64'(err_index), 64'(ei));
        chk({rq, " corrected data"}, {corr_hi, corr_lo}, fixed[63:0]);
        chk({rq, " corrected code"}, 64'(corr_code), 64'(fixed[71:64]));
    endtask

    initial begin
        logic [71:0] good;
        logic [63:0] words [4];
        int seen;
        seen = 0;
        for (int w = 3; w <= 8; w += 2) begin
            for (int v = 0; v < 256; v++) begin
                if ($countones(v[7:0]) == w && seen < 64) begin
                    colt[seen] = v[7:0];
                    seen++;
                end
            end
        end
        words[0] = 64'h0;
        words[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        words[2] = 64'hA5C3_0F96_1234_8E71;
        words[3] = 64'h0000_0001_8000_0000;

        rst_n = 1'b0; in_valid = 1'b0; in_hi = '0; in_lo = '0; in_code = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 out_valid", 64'(out_valid), 64'd0);
        chk("R9 results", {syndrome, gen_code, err_kind, err_index, corr_code}, 64'd0);
        chk("R9 corrected data", {corr_hi, corr_lo}, 64'd0);
        rst_n = 1'b1;

        for (int n = 0; n < 4; n++) begin
            good = {enc(words[n][63:32], words[n][31:0]), words[n]};
            run_case(good, 2'd0, 6'd0, good, "R3");
            for (int i = 0; i < 72; i++) begin
                if (i < 64) run_case(good ^ (72'd1 << i), 2'd1, 6'(i), good, "R4");
                else        run_case(good ^ (72'd1 << i), 2'd2, 6'(i - 64), good, "R5");
            end
        end

        // R8: idle inputs change, outputs hold
        good = {enc(words[2][63:32], words[2][31:0]), words[2]};
        run_case(good ^ (72'd1 << 40), 2'd1, 6'd40, good, "R4");
        @(negedge clk);
        in_hi = 32'h1357_9BDF; in_lo = 32'h0F0F_0F0F; in_code = 8'h3C;
        repeat (3) @(negedge clk);
        chk("R8 out_valid low", 64'(out_valid), 64'd0);
        chk("R8 err_kind held", 64'(err_kind), 64'd1);
        chk("R8 err_index held", 64'(err_index), 64'd40);
        chk("R8 corrected held", {corr_hi, corr_lo}, good[63:0]);

        // R6: every double flip is uncorrectable
        for (int n = 2; n < 4; n++) begin
            good = {enc(words[n][63:32], words[n][31:0]), words[n]};
            for (int i = 0; i < 72; i++) begin
                for (int j = i + 1; j < 72; j++) begin
                    logic [71:0] rx;
                    rx = good ^ (72'd1 << i) ^ (72'd1 << j);
                    run_case(rx, 2'd3, 6'd0, rx, "R6");
                end
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule